// File: doc/BRIEF.md
# Interrupt Destination Address Matcher

This block decides whether one local interrupt unit is a target of an interprocessor message. It takes the unit's own addressing state and a 64-bit command word. The state is an identity register, a logical destination register, a destination format register, an extended-addressing flag and a flag that says whether the message was raised by this same unit. From these it produces a single hit bit and an error flag that reports an unusable destination format. The same command word is also split into its fields: vector, delivery mode, destination mode, level, trigger and shorthand.

Each unit in a system carries one instance. The message sender puts the same command word on every instance, and the units whose hit bit is set accept the message. The block does no arbitration and no delivery. It is combinational, and a parameter adds an output register stage. The default build has that stage.

Top module: `ipi_dest_match`

## Requirements
- R1: Command fields come from fixed bit positions: vector [7:0], delivery mode [10:8], destination mode bit 11 (0 physical, 1 logical), level bit 14, trigger bit 15, shorthand [19:18].
- R2: Shorthand 1 selects only the sender, so hit equals the source-is-self flag.
- R3: Shorthand 2 selects every unit, so hit is 1 whatever the destination and format.
- R4: Shorthand 3 selects every unit except the sender, so hit equals the inverse of the source-is-self flag.
- R5: With shorthand 0, physical mode and extended addressing off, the destination is command bits [63:56]. Hit is 1 when that byte is 0xFF or when it equals the unit ID held in bits [31:24] of the identity register.
- R6: With shorthand 0, logical mode, extended addressing off and a format register of all ones (flat), hit is 1 when the logical ID (bits [31:24] of the logical register) ANDed with the destination byte is non-zero.
- R7: Under the same conditions with the format register equal to 0x0FFFFFFF (cluster), hit needs equal upper nibbles of the logical ID and the destination byte, and a non-zero AND of their lower nibbles.
- R8: With extended addressing on, logical mode and shorthand 0, the destination is the whole word [63:32]. Hit is the OR-reduction of that word ANDed with the full 32-bit logical register, and the format register is ignored.
- R9: With extended addressing on, physical mode and shorthand 0, hit is 1 when the 32-bit word [63:32] equals 0xFF or equals the 8-bit unit ID zero-extended to 32 bits.
- R10: When extended addressing is off, the shorthand is 0, the mode is logical and the format register is neither flat nor cluster, hit is 0 and the error flag is 1. In every other case the error flag is 0.
- R11: With the output stage built, every output appears one clock after its inputs, and all outputs read 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| id_reg | input | 32 | Identity register; unit ID in the top byte |
| ldr | input | 32 | Logical destination register |
| dfr | input | 32 | Destination format register (flat or cluster) |
| ext_mode | input | 1 | Extended addressing enabled |
| src_is_self | input | 1 | Message was raised by this unit |
| cmd | input | 64 | Command word; destination in the upper half |
| hit | output | 1 | This unit is a target |
| fmt_err | output | 1 | Destination format register unusable |
| vector | output | 8 | Decoded vector |
| dlv_mode | output | 3 | Decoded delivery mode |
| logical_dst | output | 1 | Decoded destination mode |
| level | output | 1 | Decoded level bit |
| trig | output | 1 | Decoded trigger mode |
| shorthand | output | 2 | Decoded shorthand |

## Verification
In the default build every result, hit, the error flag and every decoded field, is due exactly one rising edge after its inputs settle. The bench drives on a falling edge and samples on the next falling edge, so exactly one register stage lies between stimulus and check. One extra check reads the outputs just after a change of inputs and before the next rising edge, and requires the previous result to still be present. The sweeps run over every destination byte for the physical, flat and cluster paths, and the expected values are worked out from the bit arithmetic in the requirements.

// File: rtl/ipi_match_pkg.sv
package ipi_match_pkg;

   typedef enum logic [1:0] {
      SH_NONE   = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } ipi_sh_e;

   typedef struct packed {
      logic [7:0] vec;
      logic [2:0] dlv;
      logic       logical;
      logic       level;
      logic       trig;
      ipi_sh_e    sh;
   } ipi_fields_t;

   localparam int unsigned VEC_LSB   = 0;
   localparam int unsigned DLV_LSB   = 8;
   localparam int unsigned DMODE_BIT = 11;
   localparam int unsigned LEVEL_BIT = 14;
   localparam int unsigned TRIG_BIT  = 15;
   localparam int unsigned SH_LSB    = 18;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
   import ipi_match_pkg::*;
#(
   parameter int unsigned REG_W = 32
) (
   input  logic [2*REG_W-1:0] cmd,
   output ipi_fields_t        fields,
   output logic [REG_W-1:0]   dest_word
);

   initial begin
      if (REG_W < 20) $error("REG_W too small for the command layout");
   end

   assign fields.vec     = cmd[VEC_LSB +: 8];
   assign fields.dlv     = cmd[DLV_LSB +: 3];
   assign fields.logical = cmd[DMODE_BIT];
   assign fields.level   = cmd[LEVEL_BIT];
   assign fields.trig    = cmd[TRIG_BIT];
   assign fields.sh      = ipi_sh_e'(cmd[SH_LSB +: 2]);
   assign dest_word      = cmd[2*REG_W-1:REG_W];

   logic unused_dec;
   assign unused_dec = ^{cmd[13:12], cmd[17:16], cmd[REG_W-1:20]};

endmodule

// File: rtl/ipi_phys_match.sv
module ipi_phys_match #(
   parameter int unsigned ID_W  = 8,
   parameter int unsigned REG_W = 32
) (
   input  logic             ext_mode,
   input  logic [REG_W-1:0] id_reg,
   input  logic [REG_W-1:0] dest_word,
   output logic             hit
);

   localparam logic [ID_W-1:0]  BCAST_ID = {ID_W{1'b1}};
   localparam logic [REG_W-1:0] BCAST_W  = {{(REG_W-ID_W){1'b0}}, BCAST_ID};

   logic [ID_W-1:0]  own_id;
   logic [ID_W-1:0]  dest_id;
   logic [REG_W-1:0] own_wide;

   assign own_id   = id_reg[REG_W-1 -: ID_W];
   assign dest_id  = dest_word[REG_W-1 -: ID_W];
   assign own_wide = {{(REG_W-ID_W){1'b0}}, own_id};

   always_comb begin
      if (ext_mode)
         hit = (dest_word == BCAST_W) || (dest_word == own_wide);
      else
         hit = (dest_id == BCAST_ID) || (dest_id == own_id);
   end

   logic unused_phys;
   assign unused_phys = ^id_reg[REG_W-ID_W-1:0];

endmodule

// File: rtl/ipi_logical_match.sv
module ipi_logical_match #(
   parameter int unsigned ID_W  = 8,
   parameter int unsigned REG_W = 32
) (
   input  logic             ext_mode,
   input  logic [REG_W-1:0] ldr,
   input  logic [REG_W-1:0] dfr,
   input  logic [REG_W-1:0] dest_word,
   output logic             hit,
   output logic             fmt_bad
);

   localparam int unsigned HALF = ID_W / 2;
   localparam logic [REG_W-1:0] FMT_FLAT    = {REG_W{1'b1}};
   localparam logic [REG_W-1:0] FMT_CLUSTER = {4'h0, {(REG_W-4){1'b1}}};

   initial begin
      if (ID_W % 2 != 0) $error("ID_W must split into two equal halves");
   end

   logic [ID_W-1:0] lid;
   logic [ID_W-1:0] dbyte;
   logic            flat_hit;
   logic            clus_hit;

   assign lid      = ldr[REG_W-1 -: ID_W];
   assign dbyte    = dest_word[REG_W-1 -: ID_W];
   assign flat_hit = |(lid & dbyte);
   assign clus_hit = (lid[ID_W-1:HALF] == dbyte[ID_W-1:HALF]) &&
                     (|(lid[HALF-1:0] & dbyte[HALF-1:0]));

   always_comb begin
      hit     = 1'b0;
      fmt_bad = 1'b0;
      if (ext_mode)
         hit = |(ldr & dest_word);
      else if (dfr == FMT_FLAT)
         hit = flat_hit;
      else if (dfr == FMT_CLUSTER)
         hit = clus_hit;
      else
         fmt_bad = 1'b1;
   end

endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
   import ipi_match_pkg::*;
#(
   parameter int unsigned ID_W    = 8,
   parameter int unsigned REG_W   = 32,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      id_reg,
   input  logic [31:0]      ldr,
   input  logic [31:0]      dfr,
   input  logic             ext_mode,
   input  logic             src_is_self,
   input  logic [63:0]      cmd,
   output logic             hit,
   output logic             fmt_err,
   output logic [7:0]       vector,
   output logic [2:0]       dlv_mode,
   output logic             logical_dst,
   output logic             level,
   output logic             trig,
   output logic [1:0]       shorthand
);

   localparam int unsigned OUT_W = 2 + $bits(ipi_fields_t);

   initial begin
      if (REG_W != 32) $error("port widths assume REG_W of 32");
      if (ID_W > REG_W) $error("ID_W must not exceed REG_W");
   end

   ipi_fields_t      f;
   logic [REG_W-1:0] dest_word;
   logic             phy_hit;
   logic             log_hit;
   logic             fmt_bad;
   logic             hit_c;
   logic             err_c;

   ipi_cmd_decode #(.REG_W(REG_W)) u_dec (
      .cmd       (cmd),
      .fields    (f),
      .dest_word (dest_word)
   );

   ipi_phys_match #(.ID_W(ID_W), .REG_W(REG_W)) u_phys (
      .ext_mode  (ext_mode),
      .id_reg    (id_reg),
      .dest_word (dest_word),
      .hit       (phy_hit)
   );

   ipi_logical_match #(.ID_W(ID_W), .REG_W(REG_W)) u_log (
      .ext_mode  (ext_mode),
      .ldr       (ldr),
      .dfr       (dfr),
      .dest_word (dest_word),
      .hit       (log_hit),
      .fmt_bad   (fmt_bad)
   );

   always_comb begin
      unique case (f.sh)
         SH_NONE:   hit_c = f.logical ? log_hit : phy_hit;
         SH_SELF:   hit_c = src_is_self;
         SH_ALL:    hit_c = 1'b1;
         default:   hit_c = !src_is_self;
      endcase
   end

   assign err_c = (f.sh == SH_NONE) && f.logical && fmt_bad;

   logic [OUT_W-1:0] out_c;
   logic [OUT_W-1:0] out_v;
   assign out_c = {hit_c, err_c, f};

   generate
      if (REG_OUT) begin : g_reg
         logic [OUT_W-1:0] out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_c;
         end
         assign out_v = out_q;

         // R11
         out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_q == $past(out_c)));
      end else begin : g_comb
         assign out_v = out_c;
      end
   endgenerate

   ipi_fields_t f_o;
   assign f_o         = ipi_fields_t'(out_v[OUT_W-3:0]);
   assign hit         = out_v[OUT_W-1];
   assign fmt_err     = out_v[OUT_W-2];
   assign vector      = f_o.vec;
   assign dlv_mode    = f_o.dlv;
   assign logical_dst = f_o.logical;
   assign level       = f_o.level;
   assign trig        = f_o.trig;
   assign shorthand   = f_o.sh;

   // R2
   self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (f.sh == SH_SELF) |-> (hit_c == src_is_self));
   // R3
   all_incl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (f.sh == SH_ALL) |-> hit_c);
   // R4
   all_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (f.sh == SH_OTHERS && src_is_self) |-> !hit_c);
   // R5
   phys_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (f.sh == SH_NONE && !f.logical && !ext_mode && cmd[63:56] == 8'hFF) |-> hit_c);
   // R10
   bad_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_c |-> !hit_c);

endmodule

// File: tb/ipi_dest_match_test.sv
module ipi_dest_match_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] id_reg = '0;
   logic [31:0] ldr = '0;
   logic [31:0] dfr = 32'hFFFF_FFFF;
   logic        ext_mode = 1'b0;
   logic        src_is_self = 1'b0;
   logic [63:0] cmd = '0;
   logic        hit, fmt_err, logical_dst, level, trig;
   logic [7:0]  vector;
   logic [2:0]  dlv_mode;
   logic [1:0]  shorthand;

   int nchk = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   ipi_dest_match uut (
      .clk(clk), .rst_n(rst_n), .id_reg(id_reg), .ldr(ldr), .dfr(dfr),
      .ext_mode(ext_mode), .src_is_self(src_is_self), .cmd(cmd),
      .hit(hit), .fmt_err(fmt_err), .vector(vector), .dlv_mode(dlv_mode),
      .logical_dst(logical_dst), .level(level), .trig(trig), .shorthand(shorthand)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic logic [63:0] mk_cmd(input logic [31:0] d, input logic [1:0] sh,
                                          input logic lg);
      return {d, 12'h000, sh, 6'h00, lg, 3'h0, 8'h00};
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   function automatic logic exp_hit(input logic [31:0] idr, input logic [31:0] l,
                                    input logic [31:0] fm, input logic ex,
                                    input logic me, input logic [63:0] c);
      logic [1:0] sh = c[19:18];
      logic [7:0] d8 = c[63:56];
      logic [31:0] d32 = c[63:32];
      logic [7:0] lid = l[31:24];
      if (sh == 2'd1) return me;
      if (sh == 2'd2) return 1'b1;
      if (sh == 2'd3) return !me;
      if (!c[11]) begin
         if (ex) return (d32 == 32'hFF) || (d32 == {24'h0, idr[31:24]});
         return (d8 == 8'hFF) || (d8 == idr[31:24]);
      end
      if (ex) return (l & d32) != 0;
      if (fm == 32'hFFFF_FFFF) return (lid & d8) != 0;
      if (fm == 32'h0FFF_FFFF) return ((lid >> 4) == (d8 >> 4)) && ((lid & d8 & 8'h0F) != 0);
      return 1'b0;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin : main
      cmd = mk_cmd(32'hFF00_0000, 2'd2, 1'b0) | 64'h0000_0000_0000_C7FF;
      repeat (3) step();
      // R11: reset state
      chk("R11 reset hit", hit, 0);
      chk("R11 reset fields", {fmt_err, vector, dlv_mode, logical_dst, level, trig, shorthand}, 0);
      rst_n = 1'b1;
      step();

      // R1: field decode
      for (int i = 1; i <= 64; i++) begin
         cmd = {32'(i * 32'h9E37_79B9), 32'(i * 32'h7F4A_7C15) ^ 32'h5A5A_A5A5};
         step();
         chk("R1 vector", vector, cmd[7:0]);
         chk("R1 mode", dlv_mode, cmd[10:8]);
         chk("R1 dmode/level/trig", {logical_dst, level, trig}, {cmd[11], cmd[14], cmd[15]});
         chk("R1 shorthand", shorthand, cmd[19:18]);
      end

      // R5: legacy physical sweep
      id_reg = 32'h3500_00AB;
      for (int d = 0; d < 256; d++) begin
         cmd = mk_cmd({d[7:0], 24'h12_3456}, 2'd0, 1'b0);
         step();
         chk("R5 physical", hit, (d == 255) || (d == 8'h35));
         chk("R10 no err physical", fmt_err, 0);
      end

      // R6: flat logical sweep
      ldr = 32'hA400_0000; dfr = 32'hFFFF_FFFF;
      for (int d = 0; d < 256; d++) begin
         cmd = mk_cmd({d[7:0], 24'h0}, 2'd0, 1'b1);
         step();
         chk("R6 flat", hit, (d & 8'hA4) != 0);
      end

      // R7: cluster logical sweep
      ldr = 32'h5200_0000; dfr = 32'h0FFF_FFFF;
      for (int d = 0; d < 256; d++) begin
         cmd = mk_cmd({d[7:0], 24'h0}, 2'd0, 1'b1);
         step();
         chk("R7 cluster", hit, ((d >> 4) == 5) && ((d & 2) != 0));
         chk("R10 no err cluster", fmt_err, 0);
      end

      // R10: unusable format
      for (int k = 0; k < 3; k++) begin
         dfr = (k == 0) ? 32'h0 : (k == 1) ? 32'h1234_5678 : 32'hF0FF_FFFF;
         for (int d = 0; d < 16; d++) begin
            cmd = mk_cmd({d[3:0], 4'hF, 24'h0}, 2'd0, 1'b1);
            ldr = 32'hFF00_0000;
            step();
            chk("R10 bad fmt hit", hit, 0);
            chk("R10 bad fmt err", fmt_err, 1);
         end
      end

      // R2 R3 R4: shorthand overrides, format still bad
      for (int sh = 1; sh < 4; sh++)
         for (int me = 0; me < 2; me++)
            for (int lg = 0; lg < 2; lg++) begin
               src_is_self = me[0];
               cmd = mk_cmd(32'h0100_0000, sh[1:0], lg[0]);
               step();
               chk(sh == 1 ? "R2 self" : sh == 2 ? "R3 all" : "R4 others", hit,
                   (sh == 2) ? 1 : (sh == 1) ? me : !me[0]);
               chk("R10 err only with no shorthand", fmt_err, 0);
            end
      src_is_self = 1'b0;

      // R8: extended logical, format register ignored
      ext_mode = 1'b1; ldr = 32'h0003_0010; dfr = 32'h1234_5678;
      for (int k = 0; k < 32; k++) begin
         cmd = mk_cmd(32'h1 << k, 2'd0, 1'b1);
         step();
         chk("R8 extended logical", hit, (k == 4) || (k == 16) || (k == 17));
         chk("R8 no err in extended", fmt_err, 0);
      end

      // R9: extended physical
      id_reg = 32'h3500_0000;
      begin
         logic [31:0] dl [6] = '{32'h35, 32'hFF, 32'h0100_0035, 32'h3500_0000, 32'h34, 32'hFF00_0000};
         for (int k = 0; k < 6; k++) begin
            cmd = mk_cmd(dl[k], 2'd0, 1'b0);
            step();
            chk("R9 extended physical", hit, k < 2);
            chk("R9 model", hit, exp_hit(id_reg, ldr, dfr, ext_mode, src_is_self, cmd));
         end
      end
      ext_mode = 1'b0;

      // R11: one-cycle latency
      cmd = mk_cmd(32'h0, 2'd3, 1'b0); src_is_self = 1'b1;
      step();
      chk("R11 settled low", hit, 0);
      cmd = mk_cmd(32'h0, 2'd2, 1'b0);
      #1;
      chk("R11 old value before edge", hit, 0);
      step();
      chk("R11 new value after edge", hit, 1);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule